// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers every interrupt request for one processor core and hands the sequencer a single, ready-to-use vector address. Four external request pins (active low), two serial-port pins that can double as requests, and a set of internal request pulses (power-down, two serial ports, byte DMA, timer) feed it. A software set port can force any source pending. Each pin is conditioned either as a live level request or as a latched falling-edge request. Two pins are fixed level, one is fixed edge, and three are programmable.

The block applies a per-source enable mask and a global enable, then picks the highest-priority eligible request. It presents that request as `vec_valid` plus `vec_addr`. The power-down request ignores both the mask and the global enable. When the sequencer acknowledges, the latched request of the presented source is cleared and the block enters an in-service state. In that state nothing further is presented until the sequencer signals a return, so only one level of servicing is supported. Two of the vector slots are shared: a mode input selects whether they serve the second serial port's internal requests or the two serial-port pins. Four of the external pins can also be driven by a local flag output, and such a drive raises the request exactly as an external device would.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Sources in falling priority, with vectors: power-down 0x002C, IRQ2 0x0004, level pin 1 0x0008, level pin 0 0x000C, serial 0 transmit 0x0010, serial 0 receive 0x0014, edge pin 0x0018, byte DMA 0x001C, shared slot A 0x0020, shared slot B 0x0024, timer 0x0028. Source index i (1..10) has vector 4*i, and power-down is index 0. Only the highest-priority eligible source is presented.
- R2: A source other than power-down is eligible only when its bit in `imask` (bit i = source index i, 1 = enabled) is 1. Power-down is presented regardless of `imask` and of the global enable.
- R3: After reset nothing is pending, the global enable is off and the block is not in service, so `vec_valid` is 0. A maskable request that arrives before the enable is set is held and is not presented.
- R4: An edge-sensitive request is latched on a falling edge of its effective pin. It appears two cycles after the pin goes low, stays pending after the pin returns high, and is cleared only by an acknowledge of its vector.
- R5: A level-sensitive request is not latched. It appears one cycle after its pin goes low and disappears one cycle after the pin returns high. If the pin is still low after a return, the request is presented again.
- R6: `sense_edge` bit 0 selects IRQ2, bit 1 selects pin `pin_irq1_n` and bit 2 selects pin `pin_irq0_n`; 1 means edge and 0 means level. Level pins 1 and 0 are always level, and the edge pin is always edge.
- R7: With `sp1_irq_mode` = 1, slots A and B are raised by `pin_irq1_n` and `pin_irq0_n`, and `sp1_tx_req`/`sp1_rx_req` are ignored. With 0, the slots are raised by those pulses and the two pins are ignored.
- R8: For the four flagged pins (bit 0 IRQ2, 1 level pin 1, 2 level pin 0, 3 edge pin), when `flag_oe` is 1 the effective pin level is `flag_out` instead of the pad.
- R9: An acknowledge while `vec_valid` is 1 clears the pending latch of the presented source only. It puts the block in service, so `vec_valid` is 0 from the next cycle until the cycle after `ret`.
- R10: An internal request pulse, or a `sw_set` bit (bit i = source i), latches that source pending and is presentable in the cycle after the pulse.
- R11: `gie_set` turns the global enable on and `gie_clr` turns it off (clear wins). While it is off, no maskable source is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_irq2_n | input | 1 | External request pin, programmable sense |
| pin_lvl1_n | input | 1 | External level request pin 1 |
| pin_lvl0_n | input | 1 | External level request pin 0 |
| pin_edge_n | input | 1 | External edge request pin |
| flag_oe | input | 4 | Flag output enable per flagged pin |
| flag_out | input | 4 | Flag output value per flagged pin |
| pin_irq1_n | input | 1 | Serial-port pin used as request for slot A |
| pin_irq0_n | input | 1 | Serial-port pin used as request for slot B |
| sp1_irq_mode | input | 1 | 1: shared slots take the pins; 0: serial port 1 pulses |
| pwd_req | input | 1 | Power-down request pulse |
| sp0_tx_req | input | 1 | Serial port 0 transmit request pulse |
| sp0_rx_req | input | 1 | Serial port 0 receive request pulse |
| bdma_req | input | 1 | Byte DMA request pulse |
| sp1_tx_req | input | 1 | Serial port 1 transmit request pulse |
| sp1_rx_req | input | 1 | Serial port 1 receive request pulse |
| timer_req | input | 1 | Timer request pulse |
| sw_set | input | 11 | Software force-pending, one bit per source |
| imask | input | 11 | Per-source enable mask |
| sense_edge | input | 3 | Edge/level selection of the programmable pins |
| gie_set | input | 1 | Global enable set pulse |
| gie_clr | input | 1 | Global enable clear pulse |
| ack | input | 1 | Sequencer takes the presented vector |
| ret | input | 1 | Sequencer finished servicing |
| vec_valid | output | 1 | A vector is being presented |
| vec_addr | output | 14 | Vector address of the presented source |

## Verification
The bench goes after priority collisions among simultaneous pulses. A design with a wrong order or a wrong vector stride would present the lower-priority vector. It holds pins low through an acknowledge and a return, and releases them before acknowledge. A design that latched level requests would keep presenting them after release, and one that did not latch edges would lose them once the pin rose. It raises a higher-priority request while a lower one is in service, which a design without the single-level lock would present at once. It also drives the shared slots from the deselected source and drives pins through the flag output, where a wrong multiplexer would either raise spurious vectors or miss real ones.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

    localparam int NSRC      = 11;
    localparam int IDXW      = $clog2(NSRC);
    localparam int NPIN      = 6;
    localparam int NFLAG     = 4;
    localparam int NSENSE    = 3;
    localparam int STRIDE_SH = 2;
    localparam int PWD_SLOT  = 11;

    localparam int SRC_PWD   = 0;
    localparam int SRC_IRQ2  = 1;
    localparam int SRC_LVL1  = 2;
    localparam int SRC_LVL0  = 3;
    localparam int SRC_SP0TX = 4;
    localparam int SRC_SP0RX = 5;
    localparam int SRC_EDGE  = 6;
    localparam int SRC_BDMA  = 7;
    localparam int SRC_SLOTA = 8;
    localparam int SRC_SLOTB = 9;
    localparam int SRC_TIMER = 10;

    localparam int PIN_IRQ2 = 0;
    localparam int PIN_LVL1 = 1;
    localparam int PIN_LVL0 = 2;
    localparam int PIN_EDGE = 3;
    localparam int PIN_IRQ1 = 4;
    localparam int PIN_IRQ0 = 5;

    typedef struct packed {
        logic [NSRC-1:0] pend;
        logic            gie;
        logic            busy;
    } ctl_t;

    typedef struct packed {
        logic s1;
        logic s2;
    } pin_t;

endpackage

// File: rtl/irqv_pin_cond.sv
module irqv_pin_cond
    import irqv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    output logic live_req,
    output logic edge_evt
);

    pin_t st_d;
    pin_t st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin_n;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: 1'b1, s2: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    // level: follows the sampled pin; edge: one-cycle event on a high-to-low step
    assign live_req = ~edge_mode & ~st_q.s1;
    assign edge_evt = edge_mode & st_q.s2 & ~st_q.s1;

endmodule

// File: rtl/irqv_prio_pick.sv
module irqv_prio_pick #(
    parameter int N  = 11,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);

    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqv_pkg::*;
#(
    parameter int AW = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_irq2_n,
    input  logic              pin_lvl1_n,
    input  logic              pin_lvl0_n,
    input  logic              pin_edge_n,
    input  logic [NFLAG-1:0]  flag_oe,
    input  logic [NFLAG-1:0]  flag_out,
    input  logic              pin_irq1_n,
    input  logic              pin_irq0_n,
    input  logic              sp1_irq_mode,
    input  logic              pwd_req,
    input  logic              sp0_tx_req,
    input  logic              sp0_rx_req,
    input  logic              bdma_req,
    input  logic              sp1_tx_req,
    input  logic              sp1_rx_req,
    input  logic              timer_req,
    input  logic [NSRC-1:0]   sw_set,
    input  logic [NSRC-1:0]   imask,
    input  logic [NSENSE-1:0] sense_edge,
    input  logic              gie_set,
    input  logic              gie_clr,
    input  logic              ack,
    input  logic              ret,
    output logic              vec_valid,
    output logic [AW-1:0]     vec_addr
);

    ctl_t st_d;
    ctl_t st_q;

    logic [NFLAG-1:0] pad_n;
    logic [NPIN-1:0]  eff_n;
    logic [NPIN-1:0]  mode_edge;
    logic [NPIN-1:0]  pin_live;
    logic [NPIN-1:0]  pin_evt;
    logic [NSRC-1:0]  src_evt;
    logic [NSRC-1:0]  src_live;
    logic [NSRC-1:0]  gate;
    logic [NSRC-1:0]  elig;
    logic [NSRC-1:0]  clr;
    logic [IDXW-1:0]  win_idx;
    logic             win_any;
    logic             gie_w;
    logic             busy_w;

    // effective pin levels: flag output overrides the pad when enabled
    assign pad_n = {pin_edge_n, pin_lvl0_n, pin_lvl1_n, pin_irq2_n};

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        assign eff_n[g] = flag_oe[g] ? flag_out[g] : pad_n[g];
    end
    assign eff_n[PIN_IRQ1] = pin_irq1_n;
    assign eff_n[PIN_IRQ0] = pin_irq0_n;

    // fixed and programmable sensing per pin
    assign mode_edge[PIN_IRQ2] = sense_edge[0];
    assign mode_edge[PIN_LVL1] = 1'b0;
    assign mode_edge[PIN_LVL0] = 1'b0;
    assign mode_edge[PIN_EDGE] = 1'b1;
    assign mode_edge[PIN_IRQ1] = sense_edge[1];
    assign mode_edge[PIN_IRQ0] = sense_edge[2];

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        irqv_pin_cond u_cond (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_n     (eff_n[g]),
            .edge_mode (mode_edge[g]),
            .live_req  (pin_live[g]),
            .edge_evt  (pin_evt[g])
        );
    end

    // map pins and internal pulses onto source slots
    always_comb begin
        src_evt  = '0;
        src_live = '0;

        src_evt[SRC_PWD]   = pwd_req;
        src_evt[SRC_IRQ2]  = pin_evt[PIN_IRQ2];
        src_live[SRC_IRQ2] = pin_live[PIN_IRQ2];
        src_evt[SRC_LVL1]  = pin_evt[PIN_LVL1];
        src_live[SRC_LVL1] = pin_live[PIN_LVL1];
        src_evt[SRC_LVL0]  = pin_evt[PIN_LVL0];
        src_live[SRC_LVL0] = pin_live[PIN_LVL0];
        src_evt[SRC_SP0TX] = sp0_tx_req;
        src_evt[SRC_SP0RX] = sp0_rx_req;
        src_evt[SRC_EDGE]  = pin_evt[PIN_EDGE];
        src_live[SRC_EDGE] = pin_live[PIN_EDGE];
        src_evt[SRC_BDMA]  = bdma_req;
        src_evt[SRC_TIMER] = timer_req;

        if (sp1_irq_mode) begin
            src_evt[SRC_SLOTA]  = pin_evt[PIN_IRQ1];
            src_live[SRC_SLOTA] = pin_live[PIN_IRQ1];
            src_evt[SRC_SLOTB]  = pin_evt[PIN_IRQ0];
            src_live[SRC_SLOTB] = pin_live[PIN_IRQ0];
        end else begin
            src_evt[SRC_SLOTA] = sp1_tx_req;
            src_evt[SRC_SLOTB] = sp1_rx_req;
        end
    end

    // eligibility: mask and global enable, power-down exempt; single-level lock
    always_comb begin
        gate          = imask & {NSRC{st_q.gie}};
        gate[SRC_PWD] = 1'b1;
        elig          = (st_q.pend | src_live) & gate & {NSRC{~st_q.busy}};
    end

    irqv_prio_pick #(
        .N  (NSRC),
        .IW (IDXW)
    ) u_pick (
        .req (elig),
        .any (win_any),
        .idx (win_idx)
    );

    assign vec_valid = win_any;

    always_comb begin
        if (win_idx == IDXW'(SRC_PWD)) begin
            vec_addr = AW'(PWD_SLOT) << STRIDE_SH;
        end else begin
            vec_addr = AW'(win_idx) << STRIDE_SH;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;

        clr = '0;
        if (ack && win_any) begin
            clr = NSRC'(1) << win_idx;
        end

        st_d.pend = (st_q.pend & ~clr) | src_evt | sw_set;

        if (gie_clr) begin
            st_d.gie = 1'b0;
        end else if (gie_set) begin
            st_d.gie = 1'b1;
        end

        if (ret) begin
            st_d.busy = 1'b0;
        end else if (ack && win_any) begin
            st_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pend: '0, gie: 1'b0, busy: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign gie_w  = st_q.gie;
    assign busy_w = st_q.busy;

endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk
    import irqv_pkg::*;
#(
    parameter int AW = 14
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] imask,
    input logic            ack,
    input logic            ret,
    input logic            vec_valid,
    input logic [AW-1:0]   vec_addr,
    input logic            gie_w,
    input logic            busy_w
);

    localparam logic [AW-1:0] PWD_VEC  = AW'(PWD_SLOT) << STRIDE_SH;
    localparam logic [AW-1:0] LOW_VEC  = AW'(1) << STRIDE_SH;

    assert_vec_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (vec_addr[STRIDE_SH-1:0] == '0 && vec_addr >= LOW_VEC && vec_addr <= PWD_VEC));

    assert_mask_honoured_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && vec_addr != PWD_VEC) |-> imask[vec_addr[IDXW+STRIDE_SH-1:STRIDE_SH]]);

    assert_single_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && vec_valid && !ret) |=> !vec_valid);

    assert_busy_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_w |-> !vec_valid);

    assert_gie_gates_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && vec_addr != PWD_VEC) |-> gie_w);

endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .imask     (imask),
    .ack       (ack),
    .ret       (ret),
    .vec_valid (vec_valid),
    .vec_addr  (vec_addr),
    .gie_w     (gie_w),
    .busy_w    (busy_w)
);

// File: tb/irq_vector_ctrl_tb_top.sv
module irq_vector_ctrl_tb_top;
    import irqv_pkg::*;

    localparam int CLK_P = 10;
    localparam int AW    = 14;
    localparam int NROW  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pin_irq2_n = 1'b1;
    logic              pin_lvl1_n = 1'b1;
    logic              pin_lvl0_n = 1'b1;
    logic              pin_edge_n = 1'b1;
    logic [NFLAG-1:0]  flag_oe = '0;
    logic [NFLAG-1:0]  flag_out = '1;
    logic              pin_irq1_n = 1'b1;
    logic              pin_irq0_n = 1'b1;
    logic              sp1_irq_mode = 1'b0;
    logic              pwd_req = 1'b0;
    logic              sp0_tx_req = 1'b0;
    logic              sp0_rx_req = 1'b0;
    logic              bdma_req = 1'b0;
    logic              sp1_tx_req = 1'b0;
    logic              sp1_rx_req = 1'b0;
    logic              timer_req = 1'b0;
    logic [NSRC-1:0]   sw_set = '0;
    logic [NSRC-1:0]   imask = '1;
    logic [NSENSE-1:0] sense_edge = '0;
    logic              gie_set = 1'b0;
    logic              gie_clr = 1'b0;
    logic              ack = 1'b0;
    logic              ret = 1'b0;
    logic              vec_valid;
    logic [AW-1:0]     vec_addr;

    int n_chk = 0;
    int n_bad = 0;

    // row tables: pulse bits by source index, mask, expected result
    localparam logic [NSRC-1:0] ROW_PULSE [NROW] = '{
        11'b10000000000, 11'b10000010000, 11'b01010000000, 11'b00000010001,
        11'b00010100000, 11'b10000000000, 11'b01100000000, 11'b11110110001};
    localparam logic [NSRC-1:0] ROW_MASK [NROW] = '{
        11'b11111111111, 11'b11111111111, 11'b11111111111, 11'b00000000000,
        11'b11111011111, 11'b01111111111, 11'b11111111111, 11'b11111111111};
    localparam logic ROW_VALID [NROW] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
    localparam logic [AW-1:0] ROW_ADDR [NROW] = '{
        14'h0028, 14'h0010, 14'h001C, 14'h002C, 14'h001C, 14'h0000, 14'h0020, 14'h002C};

    irq_vector_ctrl #(.AW(AW)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_irq2_n   (pin_irq2_n),
        .pin_lvl1_n   (pin_lvl1_n),
        .pin_lvl0_n   (pin_lvl0_n),
        .pin_edge_n   (pin_edge_n),
        .flag_oe      (flag_oe),
        .flag_out     (flag_out),
        .pin_irq1_n   (pin_irq1_n),
        .pin_irq0_n   (pin_irq0_n),
        .sp1_irq_mode (sp1_irq_mode),
        .pwd_req      (pwd_req),
        .sp0_tx_req   (sp0_tx_req),
        .sp0_rx_req   (sp0_rx_req),
        .bdma_req     (bdma_req),
        .sp1_tx_req   (sp1_tx_req),
        .sp1_rx_req   (sp1_rx_req),
        .timer_req    (timer_req),
        .sw_set       (sw_set),
        .imask        (imask),
        .sense_edge   (sense_edge),
        .gie_set      (gie_set),
        .gie_clr      (gie_clr),
        .ack          (ack),
        .ret          (ret),
        .vec_valid    (vec_valid),
        .vec_addr     (vec_addr)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #(CLK_P/4);
    endtask

    task automatic expect_vec(input string tag, input logic ev, input logic [AW-1:0] ea);
        n_chk++;
        if (vec_valid !== ev || (ev && vec_addr !== ea)) begin
            n_bad++;
            $display("FAIL %s: got valid=%0b addr=0x%04h, expected valid=%0b addr=0x%04h",
                     tag, vec_valid, vec_addr, ev, ea);
        end
    endtask

    task automatic do_ack();
        ack = 1'b1; tick(); ack = 1'b0;
    endtask

    task automatic do_ret();
        ret = 1'b1; tick(); ret = 1'b0;
    endtask

    task automatic drain();
        imask = '1;
        gie_set = 1'b1; tick(); gie_set = 1'b0;
        for (int k = 0; k < 16; k++) begin
            if (vec_valid) begin
                do_ack();
                do_ret();
            end
        end
    endtask

    task automatic pulse_row(input logic [NSRC-1:0] p);
        pwd_req    = p[SRC_PWD];
        sp0_tx_req = p[SRC_SP0TX];
        sp0_rx_req = p[SRC_SP0RX];
        bdma_req   = p[SRC_BDMA];
        sp1_tx_req = p[SRC_SLOTA];
        sp1_rx_req = p[SRC_SLOTB];
        timer_req  = p[SRC_TIMER];
        tick();
        {pwd_req, sp0_tx_req, sp0_rx_req, bdma_req, sp1_tx_req, sp1_rx_req, timer_req} = '0;
    endtask

    initial begin
        #(CLK_P * 100000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        expect_vec("R3 reset idle", 1'b0, '0);

        // R3/R11: timer held while the global enable is off
        pulse_row(11'b10000000000);
        expect_vec("R3 held before enable", 1'b0, '0);
        gie_set = 1'b1; tick(); gie_set = 1'b0;
        expect_vec("R11 enable releases timer", 1'b1, 14'h0028);
        drain();

        // R1/R2/R10: table of simultaneous internal pulses
        for (int r = 0; r < NROW; r++) begin
            imask = ROW_MASK[r];
            pulse_row(ROW_PULSE[r]);
            expect_vec($sformatf("R1 R2 R10 row %0d", r), ROW_VALID[r], ROW_ADDR[r]);
            drain();
        end

        // R5: level pin live, relatched after return, gone on release
        pin_lvl1_n = 1'b0; tick();
        expect_vec("R5 level appears", 1'b1, 14'h0008);
        do_ack();
        expect_vec("R9 in service hides level", 1'b0, '0);
        do_ret();
        expect_vec("R5 level again after return", 1'b1, 14'h0008);
        pin_lvl1_n = 1'b1; tick();
        expect_vec("R5 level released", 1'b0, '0);

        // R4: edge pin latched
        pin_edge_n = 1'b0; tick();
        expect_vec("R4 edge not yet", 1'b0, '0);
        pin_edge_n = 1'b1; tick();
        expect_vec("R4 edge latched", 1'b1, 14'h0018);
        tick();
        expect_vec("R4 edge held after release", 1'b1, 14'h0018);
        do_ack(); do_ret();
        expect_vec("R4 edge cleared by ack", 1'b0, '0);

        // R6: programmable pin, level then edge
        sense_edge = 3'b000;
        pin_irq2_n = 1'b0; tick();
        expect_vec("R6 irq2 level", 1'b1, 14'h0004);
        pin_irq2_n = 1'b1; tick();
        expect_vec("R6 irq2 level released", 1'b0, '0);
        sense_edge = 3'b001;
        pin_irq2_n = 1'b0; tick(); tick();
        expect_vec("R6 irq2 edge latched", 1'b1, 14'h0004);
        pin_irq2_n = 1'b1; tick();
        expect_vec("R6 irq2 edge held", 1'b1, 14'h0004);
        drain();
        sense_edge = 3'b000;

        // R7: shared slots
        sp1_irq_mode = 1'b0;
        pin_irq1_n = 1'b0; tick(); tick();
        expect_vec("R7 pin ignored in port mode", 1'b0, '0);
        pin_irq1_n = 1'b1; tick();
        sp1_irq_mode = 1'b1;
        pin_irq1_n = 1'b0; tick();
        expect_vec("R7 irq1 pin on slot A", 1'b1, 14'h0020);
        pin_irq1_n = 1'b1; tick();
        expect_vec("R7 irq1 released", 1'b0, '0);
        pulse_row(11'b00100000000);
        expect_vec("R7 port pulse ignored in pin mode", 1'b0, '0);
        sense_edge = 3'b100;
        pin_irq0_n = 1'b0; tick(); tick();
        expect_vec("R7 R6 irq0 edge on slot B", 1'b1, 14'h0024);
        pin_irq0_n = 1'b1;
        drain();
        sense_edge = 3'b000;
        sp1_irq_mode = 1'b0;

        // R8: flag output drives a level pin
        flag_oe[2] = 1'b1; flag_out[2] = 1'b0; tick();
        expect_vec("R8 flag drives level pin 0", 1'b1, 14'h000C);
        flag_out[2] = 1'b1; tick();
        expect_vec("R8 flag released", 1'b0, '0);
        flag_oe[2] = 1'b0;

        // R9: single level and per-source clearing
        pulse_row(11'b10000100000);
        expect_vec("R9 sp0 rx wins", 1'b1, 14'h0014);
        do_ack();
        pulse_row(11'b00000010000);
        expect_vec("R9 blocked while in service", 1'b0, '0);
        do_ret();
        expect_vec("R9 higher one after return", 1'b1, 14'h0010);
        do_ack(); do_ret();
        expect_vec("R9 timer remains", 1'b1, 14'h0028);
        drain();
        expect_vec("R9 all drained", 1'b0, '0);

        // R10: software set latches a level slot
        sw_set[SRC_LVL0] = 1'b1; tick(); sw_set = '0;
        expect_vec("R10 software set", 1'b1, 14'h000C);
        do_ack(); do_ret();
        expect_vec("R10 software request cleared", 1'b0, '0);

        // R11/R2: enable clear blocks maskable, not power-down
        pulse_row(11'b10000000000);
        expect_vec("R11 timer with enable", 1'b1, 14'h0028);
        gie_clr = 1'b1; tick(); gie_clr = 1'b0;
        expect_vec("R11 enable cleared", 1'b0, '0);
        pulse_row(11'b00000000001);
        expect_vec("R2 power-down bypasses enable", 1'b1, 14'h002C);
        drain();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule